// File: doc/BRIEF.md
# Compare-Match Periodic Timer Channel

A single 16-bit up-counting timer channel driven by a host through a small register interface. The host picks how the counter advances (an internal clock divided by 1, 4, 16 or 64, or edges of an external clock input) and which event returns the counter to zero. It also programs four general registers that either serve as compare values or receive captured counter values.

Two pins are attached to the first two general registers. Each pin has a four-bit action code. An output code sets the pin's starting level and then clears, sets or toggles the pin whenever its register matches the counter. A capture code copies the counter into the register on a chosen input edge. Match, capture and wrap events latch status flags. A flag is removed only by reading status and then writing 0 to that flag. The interrupt output combines the flags with their enable bits. The channel counts only while its own bit, picked by a parameter, is high in a run vector shared with other channels.

Top module: `tmr_chan`

## Requirements
- R1: After reset every register reads 0 except status, which reads 0x80. Both pin outputs and the interrupt are low.
- R2: The counter advances only while `run_bits[CH_IDX]` is 1. While that bit is 0 the counter keeps its value, whatever the other run bits are.
- R3: Control bits 2:0 set to 0, 1, 2 or 3 make the counter advance exactly once per 1, 4, 16 or 64 clock cycles while running.
- R4: Control bits 7:5 select the clear source. 0 never clears. 1, 2, 5 and 6 clear on a match of general register A, B, C or D. 3 clears when `sync_clr` is high. On a counted tick where the selected register equals the counter, the counter becomes 0 on that edge, so the period is value+1 ticks, and the matching flag is set on the same edge.
- R5: A counted tick at 0xFFFF that is not a clear wraps the counter to 0 and sets status bit 4.
- R6: For pin action codes 1, 2 and 3 (and 5, 6, 7), a compare match of the pin's register drives the pin to 0, to 1, or toggles it. Code 0 leaves the pin unchanged. Pin A uses I/O-control bits 7:4 and pin B uses bits 3:0.
- R7: Writing an action code of 1 to 3 to a nibble drives that pin to 0 at once. A code of 5 to 7 drives it to 1. Code 0 keeps the pin's level.
- R8: Codes 8, 9 and 10 copy the counter into the pin's general register on a rising, falling or either edge of the pin input, and set that register's flag. Edges of the other polarity capture nothing.
- R9: Status bits 0 to 3 are the A to D match flags and bit 4 is overflow. A flag clears only when the host writes 0 to it after a status read that saw it set. Writing 1, or writing 0 with no prior read, leaves the flag set.
- R10: `irq` is high exactly when some status bit 0 to 4 is set together with the same bit of the interrupt-enable register.
- R11: Control codes 4 to 7 make the counter advance on edges of `ext_clk`. Control bits 4:3 select the edge: 0 rising, 1 falling, 2 both.
- R12: Status bit 7 reads 1 (counting up), and bits 6 and 5 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_bits | input | NCH | Shared run vector; bit CH_IDX gates this channel |
| sync_clr | input | 1 | Synchronous clear request from other channels |
| ext_clk | input | 1 | External count clock |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; data appears on rdata the next cycle |
| addr | input | 4 | Register address: 0 control, 1 mode, 2 I/O-control, 3 interrupt enable, 4 status, 5 counter, 8 to 11 general A to D |
| wdata | input | CW | Write data (8-bit registers use bits 7:0) |
| rdata | output | CW | Registered read data |
| pin_a_in | input | 1 | Capture input of pin A |
| pin_b_in | input | 1 | Capture input of pin B |
| pin_a_out | output | 1 | Compare output of pin A |
| pin_b_out | output | 1 | Compare output of pin B |
| irq | output | 1 | Interrupt request |

## Verification
A wrong counter value shows on the next counter read and, through a wrong match, as a misplaced pin edge or a missing flag within one period. A prescaler with the wrong phase or length shows as a count that is off by one or more after a window of whole prescale periods. A flag that is lost or cleared too early shows on `irq` in the same cycle and in the next status read. A capture that goes wrong leaves a stale value in the general register, which the read a few cycles after the pin edge exposes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NGR   = 4;
    localparam int NPIN  = 2;
    localparam int NFLAG = NGR + 1;
    localparam int AW    = 4;

    localparam logic [AW-1:0] ADR_CTRL  = 4'd0;
    localparam logic [AW-1:0] ADR_MODE  = 4'd1;
    localparam logic [AW-1:0] ADR_IOCTL = 4'd2;
    localparam logic [AW-1:0] ADR_IEN   = 4'd3;
    localparam logic [AW-1:0] ADR_STAT  = 4'd4;
    localparam logic [AW-1:0] ADR_COUNT = 4'd5;

    typedef enum logic [2:0] {
        CLR_NONE = 3'd0, CLR_A = 3'd1, CLR_B = 3'd2, CLR_SYNC = 3'd3,
        CLR_C = 3'd5, CLR_D = 3'd6
    } clr_sel_e;

    typedef struct packed {
        clr_sel_e    clr;
        logic [1:0]  edge_sel;
        logic [2:0]  psc;
    } ctrl_t;

    function automatic logic act_is_out(input logic [3:0] c);
        return !c[3] && (c[1:0] != 2'd0);
    endfunction

    function automatic logic act_is_cap(input logic [3:0] c);
        return c[3] && (c[2:0] <= 3'd2);
    endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [2:0] psc,
    input  logic [1:0] edge_sel,
    input  logic       ext_clk,
    output logic       tick
);
    localparam int PRE_W = 6;
    logic [PRE_W-1:0] pre;
    logic [2:0]       ext_q;
    logic             int_t, ext_t;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre   <= '0;
            ext_q <= '0;
        end else begin
            pre   <= pre + 1'b1;
            ext_q <= {ext_q[1:0], ext_clk};
        end
    end

    always_comb begin
        case (psc[1:0])
            2'd0:    int_t = 1'b1;
            2'd1:    int_t = &pre[1:0];
            2'd2:    int_t = &pre[3:0];
            default: int_t = &pre[5:0];
        endcase
        case (edge_sel)
            2'd0:    ext_t = ext_q[1] & ~ext_q[2];
            2'd1:    ext_t = ~ext_q[1] & ext_q[2];
            default: ext_t = ext_q[1] ^ ext_q[2];
        endcase
    end

    assign tick = run & (psc[2] ? ext_t : int_t);
endmodule

// File: rtl/tmr_pin.sv
module tmr_pin
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] code,
    input  logic       cfg_wr,
    input  logic [3:0] cfg_code,
    input  logic       match,
    input  logic       pin_in,
    output logic       pin_out,
    output logic       cap
);
    logic [2:0] in_q;
    logic       rise, fall;

    always_ff @(posedge clk) begin
        if (rst) in_q <= '0;
        else     in_q <= {in_q[1:0], pin_in};
    end

    assign rise = in_q[1] & ~in_q[2];
    assign fall = ~in_q[1] & in_q[2];

    always_comb begin
        cap = 1'b0;
        if (act_is_cap(code)) begin
            case (code[1:0])
                2'd0:    cap = rise;
                2'd1:    cap = fall;
                default: cap = rise | fall;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_out <= 1'b0;
        end else if (cfg_wr) begin
            if (act_is_out(cfg_code)) pin_out <= cfg_code[2];
        end else if (match && act_is_out(code)) begin
            case (code[1:0])
                2'd1:    pin_out <= 1'b0;
                2'd2:    pin_out <= 1'b1;
                default: pin_out <= ~pin_out;
            endcase
        end
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CH_IDX = 0,
    parameter int NCH    = 8,
    parameter int CW     = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] run_bits,
    input  logic           sync_clr,
    input  logic           ext_clk,
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic [3:0]     addr,
    input  logic [CW-1:0]  wdata,
    output logic [CW-1:0]  rdata,
    input  logic           pin_a_in,
    input  logic           pin_b_in,
    output logic           pin_a_out,
    output logic           pin_b_out,
    output logic           irq
);
    ctrl_t            ctrl;
    logic [7:0]       mode_r, ioctl, ien;
    logic [CW-1:0]    cnt;
    logic [CW-1:0]    gen [NGR];
    logic [NFLAG-1:0] st, arm;
    logic             tick, clr_hit, ovf_ev, run;
    logic [NGR-1:0]   hit, cap_all, cmp_ok;
    logic [NPIN-1:0]  pin_in_v, pin_out_v;
    logic             gen_sel, wr_cnt, wr_io, wr_st, rd_st;
    logic [CW-1:0]    rd_mux;
    logic             unused_run;

    assign run        = run_bits[CH_IDX];
    assign unused_run = ^run_bits;
    assign gen_sel    = (addr[3:2] == 2'b10);
    assign wr_cnt     = wr_en && addr == ADR_COUNT;
    assign wr_io      = wr_en && addr == ADR_IOCTL;
    assign wr_st      = wr_en && addr == ADR_STAT;
    assign rd_st      = rd_en && addr == ADR_STAT;
    assign pin_in_v   = {pin_b_in, pin_a_in};

    tmr_prescale u_pre (
        .clk(clk), .rst(rst), .run(run), .psc(ctrl.psc),
        .edge_sel(ctrl.edge_sel), .ext_clk(ext_clk), .tick(tick)
    );

    for (genvar g = 0; g < NGR; g++) begin : g_gr
        assign hit[g] = tick && (cnt == gen[g]) && cmp_ok[g];
        if (g < NPIN) begin : g_pin
            localparam int LSB = (NPIN - 1 - g) * 4;
            assign cmp_ok[g] = !act_is_cap(ioctl[LSB +: 4]);
            tmr_pin u_pin (
                .clk(clk), .rst(rst), .code(ioctl[LSB +: 4]),
                .cfg_wr(wr_io), .cfg_code(wdata[LSB +: 4]),
                .match(hit[g]), .pin_in(pin_in_v[g]),
                .pin_out(pin_out_v[g]), .cap(cap_all[g])
            );
        end else begin : g_cmp
            assign cmp_ok[g]  = 1'b1;
            assign cap_all[g] = 1'b0;
        end
    end

    assign pin_a_out = pin_out_v[0];
    assign pin_b_out = pin_out_v[1];

    always_comb begin
        case (ctrl.clr)
            CLR_A:    clr_hit = hit[0];
            CLR_B:    clr_hit = hit[1];
            CLR_SYNC: clr_hit = tick && sync_clr;
            CLR_C:    clr_hit = hit[2];
            CLR_D:    clr_hit = hit[3];
            default:  clr_hit = 1'b0;
        endcase
    end

    assign ovf_ev = tick && !clr_hit && !wr_cnt && (cnt == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '{clr: CLR_NONE, edge_sel: 2'd0, psc: 3'd0};
            mode_r <= '0;
            ioctl  <= '0;
            ien    <= '0;
            cnt    <= '0;
            for (int i = 0; i < NGR; i++) gen[i] <= '0;
        end else begin
            if (wr_en && addr == ADR_CTRL) ctrl <= ctrl_t'(wdata[7:0]);
            if (wr_en && addr == ADR_MODE) mode_r <= wdata[7:0];
            if (wr_io) ioctl <= wdata[7:0];
            if (wr_en && addr == ADR_IEN) ien <= wdata[7:0];
            if (wr_cnt)       cnt <= wdata;
            else if (tick)    cnt <= clr_hit ? '0 : cnt + 1'b1;
            for (int i = 0; i < NGR; i++) begin
                if (wr_en && gen_sel && addr[1:0] == 2'(i)) gen[i] <= wdata;
                else if (cap_all[i])                        gen[i] <= cnt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= '0;
            arm <= '0;
        end else begin
            for (int i = 0; i < NFLAG; i++) begin
                if (i < NGR ? (hit[i] | cap_all[i]) : ovf_ev) st[i] <= 1'b1;
                else if (wr_st && arm[i] && !wdata[i])          st[i] <= 1'b0;
            end
            if (wr_st)      arm <= '0;
            else if (rd_st) arm <= st;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (gen_sel) rd_mux = gen[addr[1:0]];
        else begin
            case (addr)
                ADR_CTRL:  rd_mux[7:0] = ctrl;
                ADR_MODE:  rd_mux[7:0] = mode_r;
                ADR_IOCTL: rd_mux[7:0] = ioctl;
                ADR_IEN:   rd_mux[7:0] = ien;
                ADR_STAT:  rd_mux[7:0] = {3'b100, st};
                ADR_COUNT: rd_mux = cnt;
                default:   rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    assign irq = |(st & ien[NFLAG-1:0]);
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
    import tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             wr_en,
    input logic [3:0]       addr,
    input logic [CW-1:0]    wdata,
    input logic [CW-1:0]    cnt,
    input logic [CW-1:0]    gen_a,
    input logic [7:0]       ctrl,
    input logic [7:0]       ioctl,
    input logic [NFLAG-1:0] st,
    input logic             tick,
    input logic             pin_a_out,
    input logic             pin_b_out,
    input logic             irq
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (cnt == '0 && !pin_a_out && !pin_b_out && !irq && st == '0));

    assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (rst)
        (!run && !(wr_en && addr == ADR_COUNT)) |=> $stable(cnt));

    assert_div4_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && ctrl[2:0] == 3'd1 && !(wr_en && addr == ADR_CTRL)) |=> !tick);

    assert_clear_on_a_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && ctrl[7:5] == 3'd1 && !ioctl[7] && cnt == gen_a
         && !(wr_en && addr == ADR_COUNT)) |=> (cnt == '0 && st[0]));

    assert_wrap_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && ctrl[7:5] == 3'd0 && cnt == '1 && !(wr_en && addr == ADR_COUNT))
        |=> (st[NGR] && cnt == '0));

    assert_write_one_keeps_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADR_STAT && (&wdata[NFLAG-1:0]))
        |=> ((st & $past(st)) == $past(st)));
endmodule

bind tmr_chan tmr_chan_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .run(run_bits[CH_IDX]), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .cnt(cnt), .gen_a(gen[0]), .ctrl(ctrl), .ioctl(ioctl),
    .st(st), .tick(tick), .pin_a_out(pin_a_out), .pin_b_out(pin_b_out), .irq(irq)
);

// File: tb/sim_tmr_chan.sv
module sim_tmr_chan;
    localparam int CLK_PERIOD = 10;
    localparam int IDX = 2;
    localparam int NCH = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic [NCH-1:0] run_bits = '0;
    logic sync_clr = 0, ext_clk = 0, wr_en = 0, rd_en = 0;
    logic [3:0] addr = '0;
    logic [15:0] wdata = '0, rdata;
    logic pin_a_in = 0, pin_b_in = 0, pin_a_out, pin_b_out, irq;
    int n_chk = 0, n_bad = 0;

    tmr_chan #(.CH_IDX(IDX), .NCH(NCH), .CW(16)) u0 (
        .clk(clk), .rst(rst), .run_bits(run_bits), .sync_clr(sync_clr),
        .ext_clk(ext_clk), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_a_in(pin_a_in), .pin_b_in(pin_b_in),
        .pin_a_out(pin_a_out), .pin_b_out(pin_b_out), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk); rd_en = 1; addr = a;
        @(negedge clk); rd_en = 0; d = rdata;
    endtask

    task automatic run_for(input int n);
        @(negedge clk); run_bits[IDX] = 1;
        repeat (n) @(negedge clk);
        run_bits[IDX] = 0;
    endtask

    task automatic clear_flags();
        logic [15:0] d;
        rd(4'd4, d); wr(4'd4, 16'h0000);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        rd(4'd0, d);  chk("R1 control", d, 16'h0000);
        rd(4'd5, d);  chk("R1 counter", d, 16'h0000);
        rd(4'd8, d);  chk("R1 general A", d, 16'h0000);
        rd(4'd4, d);  chk("R12 status after reset", d, 16'h0080);
        chk("R1 pins and irq", {13'd0, pin_a_out, pin_b_out, irq}, 16'h0000);
    endtask

    task automatic t_gating();
        logic [15:0] d;
        wr(4'd9, 16'h8000); wr(4'd10, 16'h8000); wr(4'd11, 16'h8000);
        wr(4'd5, 16'h0000);
        run_for(10);
        rd(4'd5, d); chk("R2 count after 10 enabled cycles", d, 16'd10);
        @(negedge clk); run_bits = ~(NCH'(1) << IDX);
        repeat (12) @(negedge clk);
        run_bits = '0;
        rd(4'd5, d); chk("R2 other channel bits do not count", d, 16'd10);
    endtask

    task automatic t_prescale();
        logic [15:0] d;
        wr(4'd0, 16'h0001); wr(4'd5, 16'h0000); run_for(40);
        rd(4'd5, d); chk("R3 divide by 4", d, 16'd10);
        wr(4'd0, 16'h0002); wr(4'd5, 16'h0000); run_for(64);
        rd(4'd5, d); chk("R3 divide by 16", d, 16'd4);
        wr(4'd0, 16'h0003); wr(4'd5, 16'h0000); run_for(128);
        rd(4'd5, d); chk("R3 divide by 64", d, 16'd2);
    endtask

    task automatic t_clear();
        logic [15:0] d;
        clear_flags();
        wr(4'd0, 16'h0020); wr(4'd8, 16'd4); wr(4'd5, 16'h0000); run_for(13);
        rd(4'd5, d); chk("R4 clear on A, period A+1", d, 16'd3);
        rd(4'd4, d); chk("R4 flag A set", d & 16'h0001, 16'h0001);
        wr(4'd0, 16'h00C0); wr(4'd11, 16'd2); wr(4'd5, 16'h0000); run_for(7);
        rd(4'd5, d); chk("R4 clear on D", d, 16'd1);
        rd(4'd4, d); chk("R4 flag D set", d & 16'h0008, 16'h0008);
        wr(4'd0, 16'h0060); wr(4'd5, 16'd100);
        sync_clr = 1; run_for(1); sync_clr = 0;
        rd(4'd5, d); chk("R4 synchronous clear", d, 16'd0);
        run_for(3);
        rd(4'd5, d); chk("R4 no clear without sync", d, 16'd3);
        wr(4'd11, 16'h8000);
    endtask

    task automatic t_ovf_status();
        logic [15:0] d;
        clear_flags();
        wr(4'd0, 16'h0000); wr(4'd5, 16'hFFFE); run_for(3);
        rd(4'd5, d); chk("R5 wrap to 1", d, 16'd1);
        rd(4'd4, d); chk("R5 overflow flag", d, 16'h0090);
        wr(4'd4, 16'h00FF);
        wr(4'd4, 16'h0000);
        rd(4'd4, d); chk("R9 write 0 without read keeps flag", d, 16'h0090);
        wr(4'd4, 16'h0010);
        rd(4'd4, d); chk("R9 write 1 keeps flag", d, 16'h0090);
        wr(4'd4, 16'h00EF);
        rd(4'd4, d); chk("R9 read then write 0 clears", d, 16'h0080);
    endtask

    task automatic t_irq();
        logic [15:0] d;
        clear_flags();
        wr(4'd3, 16'h0001);
        chk("R10 irq low with no flag", {15'd0, irq}, 16'd0);
        wr(4'd0, 16'h0020); wr(4'd8, 16'd2); wr(4'd5, 16'h0000); run_for(3);
        chk("R10 irq on enabled A flag", {15'd0, irq}, 16'd1);
        wr(4'd3, 16'h0002);
        chk("R10 irq low when A disabled", {15'd0, irq}, 16'd0);
        wr(4'd3, 16'h0001); clear_flags();
        chk("R10 irq low after clear", {15'd0, irq}, 16'd0);
        rd(4'd5, d); chk("R4 counter after irq run", d, 16'd0);
    endtask

    task automatic t_pins();
        wr(4'd0, 16'h0000);
        wr(4'd2, 16'h0053);
        chk("R7 initial levels 5/3", {14'd0, pin_a_out, pin_b_out}, 16'b10);
        wr(4'd8, 16'd3); wr(4'd9, 16'd5); wr(4'd5, 16'h0000); run_for(8);
        chk("R6 clear A, toggle B", {14'd0, pin_a_out, pin_b_out}, 16'b01);
        wr(4'd2, 16'h0060);
        chk("R7 code 6 sets A, code 0 keeps B", {14'd0, pin_a_out, pin_b_out}, 16'b11);
        wr(4'd5, 16'd5); run_for(1);
        chk("R6 code 0 ignores B match", {15'd0, pin_b_out}, 16'd1);
        wr(4'd2, 16'h0020);
        chk("R7 code 2 starts A low", {15'd0, pin_a_out}, 16'd0);
        wr(4'd5, 16'd3); run_for(1);
        chk("R6 code 2 sets A on match", {15'd0, pin_a_out}, 16'd1);
    endtask

    task automatic t_capture();
        logic [15:0] d;
        clear_flags();
        wr(4'd2, 16'h0089); wr(4'd5, 16'h1234);
        @(negedge clk); pin_a_in = 1; repeat (5) @(negedge clk);
        rd(4'd8, d); chk("R8 rising capture into A", d, 16'h1234);
        rd(4'd4, d); chk("R8 capture flag A", d & 16'h0001, 16'h0001);
        @(negedge clk); pin_b_in = 1; repeat (5) @(negedge clk);
        rd(4'd9, d); chk("R8 rising edge ignored by falling code", d, 16'd5);
        wr(4'd5, 16'h0777);
        @(negedge clk); pin_b_in = 0; repeat (5) @(negedge clk);
        rd(4'd9, d); chk("R8 falling capture into B", d, 16'h0777);
        wr(4'd2, 16'h00A0); wr(4'd5, 16'h0042);
        @(negedge clk); pin_a_in = 0; repeat (5) @(negedge clk);
        rd(4'd8, d); chk("R8 either-edge capture", d, 16'h0042);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_clk = 1; repeat (3) @(negedge clk);
            ext_clk = 0; repeat (3) @(negedge clk);
        end
    endtask

    task automatic t_ext();
        logic [15:0] d;
        wr(4'd2, 16'h0000);
        wr(4'd0, 16'h0004); wr(4'd5, 16'h0000);
        @(negedge clk); run_bits[IDX] = 1;
        pulses(3); repeat (4) @(negedge clk); run_bits[IDX] = 0;
        rd(4'd5, d); chk("R11 rising external edges", d, 16'd3);
        wr(4'd0, 16'h0014); wr(4'd5, 16'h0000);
        @(negedge clk); run_bits[IDX] = 1;
        pulses(3); repeat (4) @(negedge clk); run_bits[IDX] = 0;
        rd(4'd5, d); chk("R11 both external edges", d, 16'd6);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_gating();
        t_prescale();
        t_clear();
        t_ovf_status();
        t_irq();
        t_pins();
        t_capture();
        t_ext();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule